// File: doc/BRIEF.md
# Integer-plus-Fraction to Single-Precision Packer

This block turns a number given as two parts, a signed two's complement integer part and an unsigned binary fraction, into a 32-bit IEEE 754 single-precision word. The fraction is left-aligned: its top bit weighs one half and its lowest bit weighs 2^-23. Both parts together make up one magnitude, and the integer part's sign applies to the whole. For example, an integer part of -1 with fraction 0x400000 gives -1.5.

A conversion starts when `start_i` is high at a rising clock edge. The result is registered on that edge. One cycle later `done_o` is high for that cycle, and `result_o` keeps its value until the next start. Normalization finds the leading one of the joined integer and fraction bits and drops that bit as the hidden bit. The 23 bits below it form the mantissa. Any lower 1-bits that cannot fit are folded into the mantissa LSB; no round-to-nearest is done. NaN, infinity and denormal outputs are never produced.

Top module: `int_frac_to_f32`

## Requirements
- R1: While reset is held and after it is released, `result_o` is 0x00000000 and `done_o` is 0 until the first start.
- R2: `done_o` is 1 in exactly the cycles that follow a rising edge at which `start_i` was 1, and 0 otherwise.
- R3: For a non-zero integer part with leading one at bit p of its magnitude, bits 30:23 hold p+127 and the integer bits below the leading one fill the mantissa from bit 22 downward (1 gives 0x3F800000, 0x01000000 gives 0x4B800000).
- R4: A negative integer part is negated to its magnitude and bit 31 is set to 1; -1 gives 0xBF800000 and -2^31 gives 0xCF000000.
- R5: The fraction is placed directly below the integer bits, shifted right by p; -2.25 (integer -2, fraction 0x200000) gives 0xC0100000.
- R6: If any 1-bit falls below mantissa bit 0, mantissa bit 0 is forced to 1 (0x7FFFFFFF gives 0x4EFFFFFF; integer 0x100 with fraction 0x000080 gives 0x43800001).
- R7: With a zero integer part and a non-zero fraction whose leading one is at fraction bit q, the exponent field is q+104 and the fraction bits below q fill the mantissa from bit 22 (0x400000 gives 0x3F000000, 0x000001 gives 0x34000000).
- R8: Both parts zero gives +0.0, 0x00000000.
- R9: Without a start, `result_o` holds its value whatever the data inputs do.
- R10: The exponent field is never 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion of the current inputs |
| int_i | input | INT_W (32) | Signed integer part |
| frac_i | input | FRAC_W (23) | Left-aligned binary fraction |
| result_o | output | 32 | Single-precision result |
| done_o | output | 1 | One-cycle result marker |

## Verification
The bench builds the block with its defaults, a 32-bit integer part and a 23-bit fraction. This makes the full normalization range reachable. At the top end sits the most negative integer, with the largest exponent of 158 and every fraction bit discarded. At the bottom end sits a fraction of one LSB, with exponent 104 and the longest left shift. Rounding is probed where the lost bits come from the integer part alone, from the fraction alone, and where a fraction bit lands exactly on mantissa bit 0.

// File: rtl/int_frac_to_f32.sv
module int_frac_to_f32 #(
  parameter int INT_W  = 32,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [31:0]       result_o,
  output logic              done_o
);
  localparam int W    = INT_W + FRAC_W;
  localparam int PW   = $clog2(W);
  localparam int MW   = 23;
  localparam int EOFF = 127 - FRAC_W;
  localparam logic [PW-1:0] TOP = PW'(W - 1);

  logic              neg;
  logic [INT_W-1:0]  mag;
  logic [W-1:0]      joined, norm;
  logic [PW-1:0]     lead;
  logic [MW-1:0]     mant;
  logic [7:0]        expf;
  logic              sticky, nonzero;
  logic [31:0]       packed_w;

  assign neg    = int_i[INT_W-1];
  assign mag    = neg ? (~int_i + 1'b1) : int_i;
  assign joined = {mag, frac_i};

  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++)
      if (joined[i]) lead = PW'(i);
  end

  assign nonzero  = |joined;
  assign norm     = joined << (TOP - lead);
  assign mant     = norm[W-2 -: MW];
  assign sticky   = |norm[W-2-MW:0];
  assign expf     = 8'(lead) + 8'(EOFF);
  assign packed_w = nonzero ? {neg, expf, mant[MW-1:1], mant[0] | sticky} : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) result_o <= packed_w;
    end
  end

  // R2
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(result_o));
  // R8
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && int_i == '0 && frac_i == '0) |=> result_o == 32'd0);
  // R4
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && int_i != '0) |=> result_o[31] == $past(int_i[INT_W-1]));
  // R10
  no_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_o[30:23] != 8'hFF);
endmodule

// File: tb/int_frac_to_f32_tb.sv
module int_frac_to_f32_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  localparam logic [31:0] V_INT [N] = '{
    32'h00000001, 32'hFFFFFFFF, 32'h80000000, 32'h01000000,
    32'h00000001, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h7FFFFFFF,
    32'h00000100, 32'h00000100, 32'h00000100, 32'h01000001,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000};
  localparam logic [22:0] V_FRAC [N] = '{
    23'h000000, 23'h000000, 23'h000000, 23'h000000,
    23'h400000, 23'h200000, 23'h400000, 23'h000000,
    23'h000080, 23'h000100, 23'h000200, 23'h000000,
    23'h400000, 23'h000001, 23'h000003, 23'h000000};
  localparam logic [31:0] V_EXP [N] = '{
    32'h3F800000, 32'hBF800000, 32'hCF000000, 32'h4B800000,
    32'h3FC00000, 32'hC0100000, 32'hBFC00000, 32'h4EFFFFFF,
    32'h43800001, 32'h43800001, 32'h43800002, 32'h4B800001,
    32'h3F000000, 32'h34000000, 32'h34C00000, 32'h00000000};
  localparam string V_REQ [N] = '{
    "R3", "R4", "R4", "R3", "R5", "R5", "R4", "R6",
    "R6", "R5", "R5", "R6", "R7", "R7", "R7", "R8"};

  logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [31:0] int_i = '0;
  logic [22:0] frac_i = '0;
  logic [31:0] result_o;
  logic        done_o;
  int checks = 0, errors = 0;

  int_frac_to_f32 u_dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .int_i(int_i),
                         .frac_i(frac_i), .result_o(result_o), .done_o(done_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [31:0] iv, input logic [22:0] fv);
    @(negedge clk);
    int_i = iv; frac_i = fv; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", result_o, 32'd0);
        check("R1", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", result_o, 32'd0);
        check("R2", {31'd0, done_o}, 32'd0);
        for (int k = 0; k < N; k++) begin
          convert(V_INT[k], V_FRAC[k]);
          check(V_REQ[k], result_o, V_EXP[k]);
          check("R2", {31'd0, done_o}, 32'd1);
          @(negedge clk);
          check("R2", {31'd0, done_o}, 32'd0);
        end
        // R9 hold without start
        convert(32'hFFFFFFFE, 23'h200000);
        int_i = 32'h12345678; frac_i = 23'h7FFFFF;
        repeat (3) @(negedge clk);
        check("R9", result_o, 32'hC0100000);
        // R2 back-to-back starts
        @(negedge clk);
        int_i = 32'd1; frac_i = '0; start_i = 1'b1;
        @(negedge clk);
        check("R3", result_o, 32'h3F800000);
        int_i = 32'h80000000;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", {31'd0, done_o}, 32'd1);
        check("R10", result_o, 32'hCF000000);
        // R8 zero after non-zero
        convert(32'd0, 23'd0);
        check("R8", result_o, 32'd0);
      end
      begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule